// File: doc/BRIEF.md
# Processor-Side Linked-Load / Store-Conditional Reservation Register

This block sits between one processor core and the memory network. It keeps a single reservation on the core's behalf. A linked load (LL) records the target address, starts an age counter and sends a one-flit LL request to memory. The memory answers with the loaded data and a reservation key, and the block keeps that key. A later store-conditional (SC) to the same address goes out as a two-flit request. That request carries the address, the kept key and the new data. An SC that does not match a live reservation fails at once inside the block and sends nothing to the network. A plain store (SW) always goes to memory, and it cancels the reservation when its address matches.

Memory reports SC status as 0 for success and 1 for failure. A parameter chooses which convention the core sees. With `SUCCESS_NONZERO = 1` the status is inverted, so a nonzero value means success. With `SUCCESS_NONZERO = 0` the raw value is passed through. A reservation stays live for exactly 2^`AGE_W` clock edges after the LL is accepted, and the default gives 2^31. Only one network request can be outstanding at a time. The core sees `core_ready` low until the memory response arrives.

Top module: `llsc_resv_unit`

## Requirements
- R1: After reset there is no live reservation. `core_ready` is 1, and `net_req_valid` and `core_rsp_valid` are 0.
- R2: An LL (`core_op` = 0) accepted at a clock edge drives `net_req_valid` for one cycle after that edge. The request has `net_req_kind` = 0, `net_req_flits` = 1 and the LL address. The LL also arms a reservation on that address, replacing any earlier one.
- R3: One cycle after the memory response to an LL, the block drives `core_rsp_valid` with `core_rsp_data` equal to `mem_rsp_data`. The block stores `mem_rsp_key`, and the next SC that matches sends that key.
- R4: An SC (`core_op` = 1) that matches a live reservation sends one request with `net_req_kind` = 1 and `net_req_flits` = 2. The request carries the address, the stored key on `net_req_key` and `core_wdata`. The SC also clears the reservation, so a repeated SC then fails locally.
- R5: An SC with no live reservation, or with a different address, fails locally. One cycle after acceptance the block drives `core_rsp_valid` with the local failure code. There is no network request, `core_ready` stays 1 and the reservation is unchanged.
- R6: An SW (`core_op` = 2) is always sent on as `net_req_kind` = 2 with `net_req_flits` = 1 and `core_wdata`. It clears a live reservation on the same address and leaves a reservation on another address untouched. Its memory response completes to the core with `core_rsp_data` = 0.
- R7: Take an SC to the reserved address, accepted at the Nth clock edge after the edge that accepted the LL. It matches when N <= 2^`AGE_W` and fails locally when N > 2^`AGE_W`.
- R8: SC status is returned in `core_rsp_data[0]`, and all other bits are 0. With `SUCCESS_NONZERO = 1` the bit is the inverse of `mem_rsp_status`, and a local failure gives 0. With `SUCCESS_NONZERO = 0` the bit is `mem_rsp_status`, and a local failure gives 1.
- R9: After a request goes to the network, `core_ready` stays 0 until the clock edge at which `mem_rsp_valid` is seen. A `core_req` during that time is ignored and sends no network request.
- R10: A `mem_rsp_valid` pulse while nothing is outstanding is ignored. It produces no `core_rsp_valid` and does not change the stored key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| core_req | input | 1 | Core request strobe, taken when `core_ready` is 1 |
| core_op | input | 2 | 0 = LL, 1 = SC, 2 = SW; 3 is never accepted |
| core_addr | input | ADDR_W | Request address |
| core_wdata | input | DATA_W | Store data for SC and SW |
| core_ready | output | 1 | High when no network request is outstanding |
| core_rsp_valid | output | 1 | One-cycle response strobe to the core |
| core_rsp_data | output | DATA_W | LL data, SC status in bit 0, or 0 for SW |
| net_req_valid | output | 1 | One-cycle network request strobe |
| net_req_kind | output | 2 | 0 = LL, 1 = SC, 2 = write |
| net_req_flits | output | 2 | Request length in flits (1 or 2) |
| net_req_addr | output | ADDR_W | Request address |
| net_req_key | output | KEY_W | Reservation key for SC, 0 otherwise |
| net_req_wdata | output | DATA_W | Write data |
| mem_rsp_valid | input | 1 | Memory response strobe |
| mem_rsp_data | input | DATA_W | LL read data |
| mem_rsp_key | input | KEY_W | Reservation key returned for an LL |
| mem_rsp_status | input | 1 | SC status from memory: 0 success, 1 failure |

## Verification
The assertions assume that reset lasts at least one cycle. They also assume that memory answers a forwarded request with one single-cycle `mem_rsp_valid` pulse, no sooner than the edge after the request appears. The stimulus answers every forwarded request exactly once, after zero to three stall cycles. During those stalls it presents new core requests to test the hold-off. Stray memory pulses are sent only while the block is idle, and idle gaps of random length move SCs across the expiry boundary of a shortened age counter.

// File: rtl/llsc_resv_unit.sv
module llsc_resv_unit #(
  parameter int ADDR_W          = 40,
  parameter int KEY_W           = 32,
  parameter int DATA_W          = 32,
  parameter int AGE_W           = 31,
  parameter int SUCCESS_NONZERO = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_req,
  input  logic [1:0]        core_op,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              core_ready,
  output logic              core_rsp_valid,
  output logic [DATA_W-1:0] core_rsp_data,
  output logic              net_req_valid,
  output logic [1:0]        net_req_kind,
  output logic [1:0]        net_req_flits,
  output logic [ADDR_W-1:0] net_req_addr,
  output logic [KEY_W-1:0]  net_req_key,
  output logic [DATA_W-1:0] net_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic [KEY_W-1:0]  mem_rsp_key,
  input  logic              mem_rsp_status
);

  localparam logic [1:0] OP_LL = 2'd0;
  localparam logic [1:0] OP_SC = 2'd1;
  localparam logic [1:0] OP_SW = 2'd2;
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};
  localparam logic INVERT = (SUCCESS_NONZERO != 0);

  logic              busy;
  logic [1:0]        pend_op;
  logic              resv_valid;
  logic [ADDR_W-1:0] resv_addr;
  logic [KEY_W-1:0]  resv_key;
  logic [AGE_W-1:0]  age_cnt;

  wire accept    = core_req && !busy && (core_op != 2'd3);
  wire is_ll     = (core_op == OP_LL);
  wire is_sc     = (core_op == OP_SC);
  wire is_sw     = (core_op == OP_SW);
  wire addr_hit  = resv_valid && (core_addr == resv_addr);
  wire sc_local  = accept && is_sc && !addr_hit;
  wire forward   = accept && !sc_local;
  wire cancel    = accept && (is_sc || is_sw) && addr_hit;
  wire expire    = resv_valid && (age_cnt == AGE_MAX);
  wire mem_done  = busy && mem_rsp_valid;
  wire sc_status = mem_rsp_status ^ INVERT;

  assign core_ready = !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_valid <= 1'b0;
      resv_addr  <= '0;
      age_cnt    <= '0;
    end else if (accept && is_ll) begin
      resv_valid <= 1'b1;
      resv_addr  <= core_addr;
      age_cnt    <= '0;
    end else if (cancel || expire) begin
      resv_valid <= 1'b0;
    end else if (resv_valid) begin
      age_cnt <= age_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      resv_key <= '0;
    else if (mem_done && pend_op == OP_LL)
      resv_key <= mem_rsp_key;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      pend_op <= OP_LL;
    end else if (forward) begin
      busy    <= 1'b1;
      pend_op <= core_op;
    end else if (mem_done) begin
      busy    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      net_req_valid <= 1'b0;
      net_req_kind  <= OP_LL;
      net_req_flits <= 2'd0;
      net_req_addr  <= '0;
      net_req_key   <= '0;
      net_req_wdata <= '0;
    end else begin
      net_req_valid <= forward;
      if (forward) begin
        net_req_kind  <= core_op;
        net_req_flits <= is_sc ? 2'd2 : 2'd1;
        net_req_addr  <= core_addr;
        net_req_key   <= is_sc ? resv_key : '0;
        net_req_wdata <= is_ll ? '0 : core_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_rsp_valid <= 1'b0;
      core_rsp_data  <= '0;
    end else begin
      core_rsp_valid <= sc_local || mem_done;
      if (sc_local)
        core_rsp_data <= {{(DATA_W-1){1'b0}}, ~INVERT};
      else if (mem_done) begin
        case (pend_op)
          OP_LL:   core_rsp_data <= mem_rsp_data;
          OP_SC:   core_rsp_data <= {{(DATA_W-1){1'b0}}, sc_status};
          default: core_rsp_data <= '0;
        endcase
      end
    end
  end

endmodule

module llsc_resv_unit_chk #(
  parameter int AGE_W = 31
) (
  input logic             clk,
  input logic             rst_n,
  input logic             core_req,
  input logic [1:0]       core_op,
  input logic             core_ready,
  input logic             core_rsp_valid,
  input logic             net_req_valid,
  input logic [1:0]       net_req_kind,
  input logic [1:0]       net_req_flits,
  input logic             mem_rsp_valid,
  input logic             busy,
  input logic             resv_valid,
  input logic [AGE_W-1:0] age_cnt
);

  a_r2_ll_one_flit: assert property (@(posedge clk) disable iff (!rst_n)
    net_req_valid && net_req_kind == 2'd0 |-> net_req_flits == 2'd1);

  a_r4_sc_two_flit: assert property (@(posedge clk) disable iff (!rst_n)
    net_req_valid && net_req_kind == 2'd1 |-> net_req_flits == 2'd2);

  a_r4_sc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    net_req_valid && net_req_kind == 2'd1 |-> !resv_valid);

  a_r5_local_fail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    core_rsp_valid && !$past(busy) |-> !net_req_valid);

  a_r7_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    resv_valid && age_cnt == {AGE_W{1'b1}} && !(core_req && core_ready && core_op == 2'd0)
    |=> !resv_valid);

  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_rsp_valid |=> busy);

  a_r9_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    net_req_valid |=> !net_req_valid);

  a_r9_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    net_req_valid |-> !core_ready);

endmodule

bind llsc_resv_unit llsc_resv_unit_chk #(.AGE_W(AGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_op(core_op),
  .core_ready(core_ready), .core_rsp_valid(core_rsp_valid),
  .net_req_valid(net_req_valid), .net_req_kind(net_req_kind),
  .net_req_flits(net_req_flits), .mem_rsp_valid(mem_rsp_valid),
  .busy(busy), .resv_valid(resv_valid), .age_cnt(age_cnt)
);

// File: tb/llsc_resv_unit_test.sv
module llsc_resv_unit_test;
  localparam int AGE_W = 4;
  localparam int LIFE  = 1 << AGE_W;
  localparam logic [1:0] LL = 2'd0, SC = 2'd1, SW = 2'd2;

  logic clk = 0, rst_n = 0;
  logic core_req = 0;
  logic [1:0] core_op = 0;
  logic [39:0] core_addr = 0;
  logic [31:0] core_wdata = 0;
  logic mem_rsp_valid = 0, mem_rsp_status = 0;
  logic [31:0] mem_rsp_data = 0, mem_rsp_key = 0;

  logic core_ready, core_rsp_valid, net_req_valid;
  logic [31:0] core_rsp_data, net_req_key, net_req_wdata;
  logic [1:0] net_req_kind, net_req_flits;
  logic [39:0] net_req_addr;
  logic raw_ready, raw_rsp_valid, raw_net_valid;
  logic [31:0] raw_rsp_data, raw_key, raw_wdata;
  logic [1:0] raw_kind, raw_flits;
  logic [39:0] raw_addr;

  always #5 clk = ~clk;

  llsc_resv_unit #(.AGE_W(AGE_W), .SUCCESS_NONZERO(1)) uut (
    .clk, .rst_n, .core_req, .core_op, .core_addr, .core_wdata, .core_ready,
    .core_rsp_valid, .core_rsp_data, .net_req_valid, .net_req_kind, .net_req_flits,
    .net_req_addr, .net_req_key, .net_req_wdata, .mem_rsp_valid, .mem_rsp_data,
    .mem_rsp_key, .mem_rsp_status);

  llsc_resv_unit #(.AGE_W(AGE_W), .SUCCESS_NONZERO(0)) uut_raw (
    .clk, .rst_n, .core_req, .core_op, .core_addr, .core_wdata, .core_ready(raw_ready),
    .core_rsp_valid(raw_rsp_valid), .core_rsp_data(raw_rsp_data),
    .net_req_valid(raw_net_valid), .net_req_kind(raw_kind), .net_req_flits(raw_flits),
    .net_req_addr(raw_addr), .net_req_key(raw_key), .net_req_wdata(raw_wdata),
    .mem_rsp_valid, .mem_rsp_data, .mem_rsp_key, .mem_rsp_status);

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  bit m_valid = 0;
  logic [39:0] m_addr = 0;
  logic [31:0] m_key = 0;
  int m_t0 = 0;
  bit last_net = 0;

  logic [39:0] pool [3];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_hit(input int acc, input logic [39:0] a);
    return m_valid && (acc - m_t0 <= LIFE) && (a == m_addr);
  endfunction

  function automatic logic [31:0] exp_status(input logic rs, input bit nonzero_ok);
    return {31'd0, nonzero_ok ? ~rs : rs};
  endfunction

  task automatic wait_to(input int target);
    while (cyc < target - 1) @(negedge clk);
  endtask

  task automatic run_op(input logic [1:0] op, input logic [39:0] a, input logic [31:0] wd,
                        input logic [31:0] rd, input logic [31:0] rk, input logic rs,
                        input int delay);
    int acc;
    bit hit;
    core_req = 1; core_op = op; core_addr = a; core_wdata = wd;
    acc = cyc + 1;
    hit = exp_hit(acc, a);
    @(negedge clk);
    core_req = 0;
    last_net = net_req_valid;
    if (op == SC && !hit) begin
      chk(core_rsp_valid == 1, "R5 local rsp", core_rsp_valid, 1);
      chk(core_rsp_data == 0, "R8 local fail nonzero-ok", core_rsp_data, 0);
      chk(raw_rsp_data == 1, "R8 local fail raw", raw_rsp_data, 1);
      chk(net_req_valid == 0, "R5 no net", net_req_valid, 0);
      chk(core_ready == 1, "R5 ready", core_ready, 1);
      return;
    end
    chk(net_req_valid == 1, "R2/R4/R6 net valid", net_req_valid, 1);
    chk(net_req_kind == op, "R2/R4/R6 kind", net_req_kind, op);
    chk(net_req_flits == (op == SC ? 2'd2 : 2'd1), "R2/R4/R6 flits", net_req_flits, (op == SC ? 2 : 1));
    chk(net_req_addr == a, "R2/R4/R6 addr", net_req_addr, a);
    chk(net_req_key == (op == SC ? m_key : 32'd0), "R3/R4 key", net_req_key, (op == SC ? m_key : 0));
    if (op != LL) chk(net_req_wdata == wd, "R4/R6 wdata", net_req_wdata, wd);
    chk(core_ready == 0, "R9 busy", core_ready, 0);
    chk(core_rsp_valid == 0, "R9 no early rsp", core_rsp_valid, 0);
    if (op == LL) begin m_valid = 1; m_addr = a; m_t0 = acc; end
    else if (hit) m_valid = 0;
    for (int i = 0; i < delay; i++) begin
      core_req = 1; core_op = LL; core_addr = a ^ 40'h80;
      @(negedge clk);
      chk(net_req_valid == 0, "R9 held off", net_req_valid, 0);
      chk(core_ready == 0, "R9 still busy", core_ready, 0);
    end
    core_req = 0;
    mem_rsp_valid = 1; mem_rsp_data = rd; mem_rsp_key = rk; mem_rsp_status = rs;
    @(negedge clk);
    mem_rsp_valid = 0;
    chk(core_rsp_valid == 1, "R3 rsp valid", core_rsp_valid, 1);
    chk(core_ready == 1, "R9 ready again", core_ready, 1);
    case (op)
      LL: chk(core_rsp_data == rd, "R3 ll data", core_rsp_data, rd);
      SC: begin
        chk(core_rsp_data == exp_status(rs, 1), "R8 sc status nonzero-ok", core_rsp_data, exp_status(rs, 1));
        chk(raw_rsp_data == exp_status(rs, 0), "R8 sc status raw", raw_rsp_data, exp_status(rs, 0));
      end
      default: chk(core_rsp_data == 0, "R6 sw rsp", core_rsp_data, 0);
    endcase
    if (op == LL) m_key = rk;
  endtask

  task automatic stray(input logic [31:0] k);
    mem_rsp_valid = 1; mem_rsp_key = k; mem_rsp_data = 32'hDEAD;
    @(negedge clk);
    mem_rsp_valid = 0;
    chk(core_rsp_valid == 0, "R10 stray ignored", core_rsp_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    pool[0] = 40'h12_3456_7890; pool[1] = 40'hFF_0000_0040; pool[2] = 40'h00_0000_0004;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(core_ready == 1, "R1 ready", core_ready, 1);
    chk(net_req_valid == 0, "R1 net idle", net_req_valid, 0);
    chk(core_rsp_valid == 0, "R1 rsp idle", core_rsp_valid, 0);

    run_op(SC, pool[0], 32'h1, 0, 0, 0, 0);
    run_op(LL, pool[0], 0, 32'hAAAA_0001, 32'h0000_0101, 0, 2);
    run_op(SC, pool[0], 32'h5555, 0, 0, 1'b0, 1);
    run_op(SC, pool[0], 32'h5556, 0, 0, 1'b0, 0);
    chk(last_net == 0, "R4 cleared after sc", last_net, 0);

    run_op(LL, pool[0], 0, 32'h77, 32'h0000_0202, 0, 0);
    run_op(SW, pool[1], 32'h9, 0, 0, 0, 0);
    run_op(SC, pool[0], 32'h10, 0, 0, 1'b1, 0);
    chk(last_net == 1, "R6 sw miss keeps resv", last_net, 1);

    run_op(LL, pool[2], 0, 32'h88, 32'h0000_0303, 0, 3);
    run_op(SW, pool[2], 32'hA, 0, 0, 0, 1);
    run_op(SC, pool[2], 32'hB, 0, 0, 0, 0);
    chk(last_net == 0, "R6 sw hit clears", last_net, 0);

    run_op(LL, pool[1], 0, 32'h99, 32'h0000_0404, 0, 0);
    stray(32'hBAD0_BAD0);
    run_op(SC, pool[1], 32'hC, 0, 0, 0, 0);
    chk(last_net == 1, "R10 key kept (key checked in sc)", last_net, 1);

    run_op(LL, pool[0], 0, 32'h1, 32'h0000_0505, 0, 0);
    wait_to(m_t0 + LIFE);
    run_op(SC, pool[0], 32'hD, 0, 0, 0, 0);
    chk(last_net == 1, "R7 last live edge hits", last_net, 1);
    run_op(LL, pool[0], 0, 32'h2, 32'h0000_0606, 0, 0);
    wait_to(m_t0 + LIFE + 1);
    run_op(SC, pool[0], 32'hE, 0, 0, 0, 0);
    chk(last_net == 0, "R7 expired fails locally", last_net, 0);

    for (int i = 0; i < 400; i++) begin
      logic [1:0] op;
      op = 2'($urandom % 3);
      if ($urandom % 8 == 0) stray($urandom);
      run_op(op, pool[$urandom % 3], $urandom, $urandom, $urandom, 1'($urandom % 2),
             int'($urandom % 4));
      repeat ($urandom % 6) @(negedge clk);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule